// File: doc/BRIEF.md
# On-Off-Keyed Receiver Bit Synchronizer

This block sits behind the envelope detector and ADC of a simple on-off-keyed radio. It takes unsigned envelope samples, each marked by a strobe, and turns them into packet bits. It works in three phases that always run in the same order. In the first phase it hunts for a carrier. In the second it learns where the symbol boundaries lie and what level separates on from off. In the third it slices the payload one bit per symbol. Each phase supplies the setting that the next one uses.

When the carrier is found, the first threshold is taken from the energy of the alternating preamble. During a training window, the block records the largest and smallest one-symbol matched-filter output at every sample offset. It then takes the offset with the largest peak as the sampling instant, and sets the bit threshold midway between that offset's peak and trough. A two-on-symbol mark at the end of the preamble gives the packet start. A fixed payload length, or a sustained loss of energy, returns the block to hunting.

Top module: `ook_sync_slicer`

## Requirements
- R1: While reset is held and on the first cycle after it, `carrier_det`, `pkt_start` and `bit_vld` are all 0.
- R2: `carrier_det` rises only after the average of the last 2*SPS samples has exceeded `cfg_floor` for `cfg_cd_syms`*SPS consecutive strobed samples (a value of 0 counts as 1). A burst that is shorter than this never raises it.
- R3: A signal whose two-symbol average never exceeds `cfg_floor` produces no carrier, no `pkt_start` and no bits, even if it carries a complete preamble.
- R4: Over TRAIN_SYMS symbols after detection, the sampling offset is the one with the largest one-symbol sum, with ties going to the lowest offset. The bit threshold is the midpoint of that offset's largest and smallest sums. Payload slicing is therefore correct for any pair of on and off levels and for any sample alignment.
- R5: The preamble is alternating symbols that begin with an on-symbol, ended by two consecutive on-symbols. When the second on-symbol of that mark is decided against the carrier-phase threshold, `pkt_start` pulses for exactly one cycle while `carrier_det` is high.
- R6: After `pkt_start`, one `bit_vld` pulse is issued per symbol, with `bit_data` = 1 for an on-symbol, in the order sent. No bit appears outside a packet, and no bit appears in the same cycle as `pkt_start`.
- R7: After PKT_BITS-PRE_BITS payload bits, `carrier_det` falls together with the last bit and no further bits follow. The block does not re-detect on the idle noise that follows.
- R8: If the two-symbol average stays at or below `cfg_floor` for DROP_SYMS*SPS consecutive samples after detection, `carrier_det` falls and bit output stops. Short zero runs in the payload do not cause this.
- R9: The value on `smp_data` has no effect in any cycle where `smp_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Unsigned envelope sample |
| cfg_floor | input | SAMPLE_W | Noise floor compared against the two-symbol average |
| cfg_cd_syms | input | CD_W | Number of symbols the average must stay above the floor |
| carrier_det | output | 1 | Carrier present, for the link layer |
| pkt_start | output | 1 | One-cycle pulse at the end of the preamble |
| bit_vld | output | 1 | Payload bit strobe |
| bit_data | output | 1 | Sliced payload bit |

## Verification
The hardest state to reach is a carrier drop in the middle of a payload. The preamble has to be detected, trained on and framed first, and the payload must then avoid zero runs long enough to look like a lost carrier. The bench builds its payloads from a pseudo-random sequence that forces an on-symbol after two off-symbols, then cuts one packet after 40 bits and switches to floor-level noise. A second packet uses different levels and a sample offset of three, so that the learned phase and threshold differ from those of the first packet. Junk values sit on the sample bus between strobes throughout.

// File: rtl/ook_sync_pkg.sv
package ook_sync_pkg;
   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_TRAIN = 2'd1,
      ST_ALIGN = 2'd2,
      ST_DATA  = 2'd3
   } sync_st_t;
endpackage

// File: rtl/ook_msum.sv
// Running sum of the last LEN strobed samples.
module ook_msum #(
   parameter int DW  = 8,
   parameter int LEN = 8,
   localparam int SW = DW + $clog2(LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] in_data,
   output logic [SW-1:0] sum
);
   generate
      if (LEN == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)      sum <= '0;
            else if (in_vld) sum <= SW'(in_data);
      end else begin : g_line
         logic [DW-1:0] tap [LEN];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < LEN; i++) tap[i] <= '0;
               sum <= '0;
            end else if (in_vld) begin
               tap[0] <= in_data;
               for (int i = 1; i < LEN; i++) tap[i] <= tap[i-1];
               sum <= sum + SW'(in_data) - SW'(tap[LEN-1]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ook_carrier.sv
// Carrier presence: qualifies entry (found) and loss (lost) from the two-symbol average.
module ook_carrier #(
   parameter int DW        = 8,
   parameter int SW2       = 12,
   parameter int CD_W      = 4,
   parameter int SPS       = 8,
   parameter int DROP_SYMS = 4,
   localparam int AVG_SH   = $clog2(2*SPS),
   localparam int RUN_W    = CD_W + $clog2(SPS) + 1,
   localparam int LOW_LIM  = DROP_SYMS * SPS,
   localparam int LOW_W    = $clog2(LOW_LIM + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mvld,
   input  logic [SW2-1:0]  msum2,
   input  logic [DW-1:0]   floor_lvl,
   input  logic [CD_W-1:0] cd_syms,
   input  logic            hunting,
   output logic            found,
   output logic            lost
);
   logic [DW-1:0]    avg;
   logic             above;
   logic [CD_W-1:0]  cd_eff;
   logic [RUN_W-1:0] need;
   logic [RUN_W-1:0] run_hi;
   logic [LOW_W-1:0] run_lo;

   assign avg    = DW'(msum2 >> AVG_SH);
   assign above  = avg > floor_lvl;
   assign cd_eff = (cd_syms == '0) ? CD_W'(1) : cd_syms;
   assign need   = RUN_W'(cd_eff) << $clog2(SPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_hi <= '0;
      else if (!hunting) run_hi <= '0;
      else if (mvld) begin
         if (!above)           run_hi <= '0;
         else if (run_hi < need) run_hi <= run_hi + RUN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_lo <= '0;
      else if (hunting) run_lo <= '0;
      else if (mvld) begin
         if (above)                         run_lo <= '0;
         else if (run_lo < LOW_W'(LOW_LIM)) run_lo <= run_lo + LOW_W'(1);
      end
   end

   assign found = hunting && mvld && above && ((run_hi + RUN_W'(1)) >= need);
   assign lost  = !hunting && mvld && !above && ((run_lo + LOW_W'(1)) >= LOW_W'(LOW_LIM));
endmodule

// File: rtl/ook_phase_est.sv
// Per-offset peak/trough tracking of the one-symbol sum; picks the strongest offset.
module ook_phase_est #(
   parameter int SW1 = 11,
   parameter int SPS = 8,
   localparam int PH_W = $clog2(SPS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            upd,
   input  logic [PH_W-1:0] ph,
   input  logic [SW1-1:0]  msum1,
   output logic [PH_W-1:0] best,
   output logic [SW1-1:0]  mid
);
   logic [SW1-1:0] peak   [SPS];
   logic [SW1-1:0] trough [SPS];

   generate
      for (genvar g = 0; g < SPS; g++) begin : g_ph
         logic [SW1-1:0] pk_r, tr_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n || clr) begin
               pk_r <= '0;
               tr_r <= '1;
            end else if (upd && (ph == PH_W'(g))) begin
               if (msum1 > pk_r) pk_r <= msum1;
               if (msum1 < tr_r) tr_r <= msum1;
            end
         end
         assign peak[g]   = pk_r;
         assign trough[g] = tr_r;
      end
   endgenerate

   always_comb begin
      logic [SW1-1:0] bp;
      best = '0;
      bp   = peak[0];
      for (int i = 1; i < SPS; i++) begin
         if (peak[i] > bp) begin
            bp   = peak[i];
            best = PH_W'(i);
         end
      end
      mid = SW1'(((SW1+1)'(peak[best]) + (SW1+1)'(trough[best])) >> 1);
   end
endmodule

// File: rtl/ook_sync_slicer.sv
module ook_sync_slicer
   import ook_sync_pkg::*;
#(
   parameter int SAMPLE_W   = 8,
   parameter int SPS        = 8,
   parameter int CD_W       = 4,
   parameter int TRAIN_SYMS = 8,
   parameter int DROP_SYMS  = 4,
   parameter int PRE_BITS   = 20,
   parameter int PKT_BITS   = 200
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [SAMPLE_W-1:0] cfg_floor,
   input  logic [CD_W-1:0]     cfg_cd_syms,
   output logic                carrier_det,
   output logic                pkt_start,
   output logic                bit_vld,
   output logic                bit_data
);
   localparam int PH_W   = $clog2(SPS);
   localparam int SW1    = SAMPLE_W + $clog2(SPS);
   localparam int SW2    = SAMPLE_W + $clog2(2*SPS);
   localparam int PAY    = PKT_BITS - PRE_BITS;
   localparam int BC_W   = $clog2(PAY + 1);
   localparam int TR_LIM = TRAIN_SYMS * SPS;
   localparam int TR_W   = $clog2(TR_LIM + 1);

   generate
      if ((SPS < 2) || ((SPS & (SPS - 1)) != 0)) begin : g_bad_sps
         $error("SPS must be a power of two of at least 2");
      end
      if (PKT_BITS <= PRE_BITS) begin : g_bad_len
         $error("PKT_BITS must exceed PRE_BITS");
      end
      if (TRAIN_SYMS + 2 >= PRE_BITS) begin : g_bad_train
         $error("training window must fit inside the preamble");
      end
      if (DROP_SYMS < 1) begin : g_bad_drop
         $error("DROP_SYMS must be at least 1");
      end
   endgenerate

   sync_st_t        st;
   logic            mvld;
   logic [SW1-1:0]  msum1;
   logic [SW2-1:0]  msum2;
   logic            found, lost, hunting;
   logic [PH_W-1:0] ph, best, best_q;
   logic [SW1-1:0]  mid, bthr_q, tthr_q;
   logic [TR_W-1:0] train_cnt;
   logic [BC_W-1:0] bitcnt;
   logic            hist, at_pick, over_t, over_b, upd;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mvld <= 1'b0;
      else        mvld <= smp_vld;

   ook_msum #(.DW(SAMPLE_W), .LEN(SPS)) u_sum1 (
      .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .in_data(smp_data), .sum(msum1));

   ook_msum #(.DW(SAMPLE_W), .LEN(2*SPS)) u_sum2 (
      .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .in_data(smp_data), .sum(msum2));

   assign hunting = (st == ST_HUNT);

   ook_carrier #(.DW(SAMPLE_W), .SW2(SW2), .CD_W(CD_W), .SPS(SPS), .DROP_SYMS(DROP_SYMS)) u_car (
      .clk(clk), .rst_n(rst_n), .mvld(mvld), .msum2(msum2), .floor_lvl(cfg_floor),
      .cd_syms(cfg_cd_syms), .hunting(hunting), .found(found), .lost(lost));

   assign upd = (st == ST_TRAIN) && mvld && (train_cnt != TR_W'(TR_LIM));

   ook_phase_est #(.SW1(SW1), .SPS(SPS)) u_pe (
      .clk(clk), .rst_n(rst_n), .clr(found), .upd(upd), .ph(ph), .msum1(msum1),
      .best(best), .mid(mid));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     ph <= '0;
      else if (found) ph <= '0;
      else if (mvld)  ph <= ph + PH_W'(1);

   assign at_pick = mvld && (ph == best_q);
   assign over_t  = msum1 > tthr_q;
   assign over_b  = msum1 > bthr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_HUNT;
         carrier_det <= 1'b0;
         pkt_start   <= 1'b0;
         bit_vld     <= 1'b0;
         bit_data    <= 1'b0;
         tthr_q      <= '0;
         bthr_q      <= '0;
         best_q      <= '0;
         train_cnt   <= '0;
         bitcnt      <= '0;
         hist        <= 1'b0;
      end else begin
         pkt_start <= 1'b0;
         bit_vld   <= 1'b0;
         if (lost) begin
            st          <= ST_HUNT;
            carrier_det <= 1'b0;
         end else begin
            case (st)
               ST_HUNT: if (found) begin
                  st          <= ST_TRAIN;
                  carrier_det <= 1'b1;
                  tthr_q      <= SW1'(msum2 >> 1);
                  train_cnt   <= '0;
               end
               ST_TRAIN: begin
                  if (train_cnt == TR_W'(TR_LIM)) begin
                     best_q <= best;
                     bthr_q <= mid;
                     hist   <= 1'b0;
                     st     <= ST_ALIGN;
                  end else if (mvld) begin
                     train_cnt <= train_cnt + TR_W'(1);
                  end
               end
               ST_ALIGN: if (at_pick) begin
                  if (hist && over_t) begin
                     pkt_start <= 1'b1;
                     bitcnt    <= '0;
                     st        <= ST_DATA;
                  end else begin
                     hist <= over_t;
                  end
               end
               ST_DATA: if (at_pick) begin
                  bit_vld  <= 1'b1;
                  bit_data <= over_b;
                  if (bitcnt == BC_W'(PAY - 1)) begin
                     st          <= ST_HUNT;
                     carrier_det <= 1'b0;
                  end else begin
                     bitcnt <= bitcnt + BC_W'(1);
                  end
               end
               default: st <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/ook_sync_chk.sv
module ook_sync_chk #(
   parameter int PAY_BITS = 180
) (
   input logic clk,
   input logic rst_n,
   input logic smp_vld,
   input logic carrier_det,
   input logic pkt_start,
   input logic bit_vld
);
   int unsigned seen;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         seen <= 0;
      else if (pkt_start) seen <= 0;
      else if (bit_vld)   seen <= seen + 1;

   assert_start_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |=> !pkt_start);
   assert_start_with_carrier_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |-> carrier_det);
   assert_bit_under_carrier_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld |-> $past(carrier_det));
   assert_no_bit_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_start && bit_vld));
   assert_rise_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier_det) |-> $past(smp_vld, 2));
   assert_bit_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seen <= PAY_BITS);
endmodule

bind ook_sync_slicer ook_sync_chk #(.PAY_BITS(PKT_BITS - PRE_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .carrier_det(carrier_det),
   .pkt_start(pkt_start), .bit_vld(bit_vld));

// File: tb/sim_ook_sync_slicer.sv
`timescale 1ns/1ps
module sim_ook_sync_slicer;
   localparam int SPS   = 8;
   localparam int PAY   = 180;
   localparam int NOISE = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       smp_vld;
   logic [7:0] smp_data;
   logic [7:0] cfg_floor;
   logic [3:0] cfg_cd_syms;
   logic       carrier_det, pkt_start, bit_vld, bit_data;

   ook_sync_slicer u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .cfg_floor(cfg_floor), .cfg_cd_syms(cfg_cd_syms), .carrier_det(carrier_det),
      .pkt_start(pkt_start), .bit_vld(bit_vld), .bit_data(bit_data));

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   bit expq[$];
   int smp_cnt = 0, pre_base = 0, rise_at = -1;
   int rises = 0, starts = 0, extra = 0;
   bit in_pkt = 0, car_q = 0;
   logic [15:0] lfsr = 16'hACE1;
   int zrun = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (pkt_start) begin
            starts++;
            in_pkt = 1;
         end
         if (bit_vld) begin
            check(in_pkt, "R6", "bit outside packet", 0, 1);
            if (expq.size() > 0) begin
               bit e;
               e = expq.pop_front();
               check(bit_data == e, "R6", "payload bit", int'(bit_data), int'(e));
            end else begin
               extra++;
            end
         end
         if (carrier_det && !car_q) begin
            rises++;
            rise_at = smp_cnt - pre_base;
         end
         if (!carrier_det && car_q) in_pkt = 0;
         car_q = carrier_det;
      end
   end

   task automatic put_smp(input logic [7:0] v);
      @(negedge clk);
      smp_vld  = 1'b1;
      smp_data = v;
      smp_cnt++;
      @(negedge clk);
      smp_vld  = 1'b0;
      smp_data = 8'hFF;   // R9: junk between strobes
   endtask

   task automatic put_sym(input bit b, input logic [7:0] hi, input logic [7:0] lo);
      repeat (SPS) put_smp(b ? hi : lo);
   endtask

   task automatic idle(input int n);
      repeat (n) put_smp(8'(NOISE));
   endtask

   // Driver: preamble, sync mark, payload; pushes expected payload bits
   task automatic send_pkt(input logic [7:0] hi, input logic [7:0] lo,
                           input int n_pay, input bit push);
      pre_base = smp_cnt;
      for (int i = 0; i < 18; i++) put_sym((i % 2) == 0, hi, lo);
      put_sym(1'b1, hi, lo);
      put_sym(1'b1, hi, lo);
      zrun = 0;
      for (int i = 0; i < n_pay; i++) begin
         bit b;
         lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
         b = lfsr[0];
         if (zrun == 2) b = 1'b1;
         zrun = b ? 0 : zrun + 1;
         if (push) expq.push_back(b);
         put_sym(b, hi, lo);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int xb;
      rst_n = 1'b0; smp_vld = 1'b0; smp_data = 8'hFF;
      cfg_floor = 8'd60; cfg_cd_syms = 4'd4;
      repeat (5) @(negedge clk);
      check(carrier_det == 1'b0, "R1", "carrier in reset", int'(carrier_det), 0);
      check(pkt_start == 1'b0, "R1", "start in reset", int'(pkt_start), 0);
      check(bit_vld == 1'b0, "R1", "bit_vld in reset", int'(bit_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(carrier_det == 1'b0 && bit_vld == 1'b0, "R1", "outputs after reset", int'(carrier_det), 0);

      // R3: noise below floor
      idle(60);
      check(rises == 0, "R3", "carrier on noise", rises, 0);

      // R2: burst shorter than the qualifying run
      put_sym(1'b1, 8'd200, 8'd20);
      put_sym(1'b0, 8'd200, 8'd20);
      idle(40);
      check(rises == 0, "R2", "carrier on short burst", rises, 0);

      // Full packet, strong levels
      send_pkt(8'd200, 8'd20, PAY, 1'b1);
      idle(40);
      check(rises == 1, "R2", "carrier rises once", rises, 1);
      check(rise_at >= 32 && rise_at <= 44, "R2", "detect sample index", rise_at, 36);
      check(starts == 1, "R5", "packet starts", starts, 1);
      check(expq.size() == 0, "R6", "bits missing", expq.size(), 0);
      check(extra == 0, "R7", "bits past payload", extra, 0);
      check(carrier_det == 1'b0, "R7", "carrier after payload", int'(carrier_det), 0);
      idle(40);
      check(rises == 1, "R7", "re-detect on tail noise", rises, 1);

      // R4: other levels, shifted sample alignment, shorter qualify run
      cfg_cd_syms = 4'd2;
      idle(3);
      send_pkt(8'd150, 8'd40, PAY, 1'b1);
      idle(40);
      check(rises == 2, "R4", "carrier rises", rises, 2);
      check(rise_at >= 16 && rise_at <= 30, "R2", "detect index cd=2", rise_at, 22);
      check(starts == 2, "R4", "packet starts", starts, 2);
      check(expq.size() == 0, "R4", "bits missing", expq.size(), 0);
      check(extra == 0, "R4", "extra bits", extra, 0);

      // R8: carrier lost mid-payload
      cfg_cd_syms = 4'd4;
      send_pkt(8'd200, 8'd20, 40, 1'b1);
      @(negedge clk);
      check(carrier_det == 1'b1, "R8", "carrier before loss", int'(carrier_det), 1);
      idle(80);
      check(carrier_det == 1'b0, "R8", "carrier after loss", int'(carrier_det), 0);
      check(expq.size() == 0, "R8", "bits before loss", expq.size(), 0);
      check(extra <= 6, "R8", "bits during loss", extra, 5);
      check(starts == 3, "R8", "packet starts", starts, 3);
      xb = extra;

      // R3: preamble below a raised floor
      cfg_floor = 8'd120;
      send_pkt(8'd150, 8'd40, 0, 1'b0);
      idle(40);
      check(rises == 3, "R3", "carrier under high floor", rises, 3);
      check(starts == 3, "R3", "start under high floor", starts, 3);
      check(extra == xb, "R3", "bits under high floor", extra, xb);

      // Recovery after a drop
      cfg_floor = 8'd60;
      send_pkt(8'd200, 8'd20, PAY, 1'b1);
      idle(40);
      check(starts == 4, "R5", "start after recovery", starts, 4);
      check(expq.size() == 0, "R6", "bits after recovery", expq.size(), 0);
      check(extra == xb, "R7", "extra after recovery", extra, xb);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule